// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This block watches an 8-bit input port and records, per pin, that the pin has changed level. Each pin is brought into the clock domain by a two-stage synchronizer. A level change is detected by comparing the synchronized value with its value one clock earlier. A detected change latches a pending flag for that pin, but only when the 4-pin group holding the pin has its interrupt enabled. Pins 0 to 3 form the low group and pins 4 to 7 the high group.

Software reaches the unit through a simple register port with an address, a write strobe, write data and combinational read data. One address returns the eight pending flags. Writing a one to a flag bit clears that flag, and writing a zero leaves it alone. A second address holds the two group enables. A single registered interrupt request is high while any flag is pending.

Top module: `pcint_top`

## Requirements
- R1: After reset, all eight flags read 0, both group enables read 0 and `irq_o` is 0.
- R2: A change of level, in either direction, on pin i sets flag bit i when its group is enabled. The flag is visible on the third rising clock edge after the pin changes: two synchronizer edges, then one edge to register the flag.
- R3: The enable register is at address 1. Bit 0 enables pins 0 to 3 and bit 1 enables pins 4 to 7, with 1 meaning enabled. Bits 7:2 read as 0. Changes on pins in a disabled group set no flag.
- R4: A write to address 0 clears every flag whose bit in the write data is 1, and no other flag.
- R5: Zero bits in a write to address 0 leave the matching flags unchanged.
- R6: If a detected change and a clearing write hit the same flag on the same clock edge, the flag ends up set.
- R7: Clearing a group enable leaves flags that are already pending untouched.
- R8: `irq_o` is a registered OR of the flags. It rises one clock after the first flag is set and falls one clock after the last flag is cleared.
- R9: Reads are combinational. Address 0 returns the flags, address 1 returns the enables, and addresses 2 and 3 return 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous port pin levels |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A pin change driven between clock edges appears in the flags on the third rising edge after it and in `irq_o` on the fourth. The bench drives pins on falling edges and samples exactly two and three edges later, so both a late flag and an early flag are reported. A register write takes effect on the edge that samples it, and the bench reads the result on the following falling edge. `irq_o` is checked one edge after that, which confirms that it trails the flags by one register stage. The collision case is arranged so that the third edge after a pin change is the same edge that samples a clearing write.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int NPINS    = 8;
  localparam int GRP_SIZE = 4;
  localparam int NGRP     = NPINS / GRP_SIZE;
  localparam int ADDR_W   = 2;
  localparam int SYNC_STG = 2;

  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;

  typedef logic [NPINS-1:0] pin_vec_t;
  typedef logic [NGRP-1:0]  grp_vec_t;

  // Expand one enable bit per group to one mask bit per pin.
  function automatic pin_vec_t group_mask(grp_vec_t en);
    pin_vec_t m;
    for (int g = 0; g < NGRP; g++) begin
      for (int b = 0; b < GRP_SIZE; b++) begin
        m[g*GRP_SIZE+b] = en[g];
      end
    end
    return m;
  endfunction

  // Next flag state: clear first, then set, so a set event always survives.
  function automatic pin_vec_t flag_next(pin_vec_t cur, pin_vec_t set_v, pin_vec_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // Pins whose level differs between two samples.
  function automatic pin_vec_t level_change(pin_vec_t now_v, pin_vec_t old_v);
    return now_v ^ old_v;
  endfunction
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/pcint_edge.sv
module pcint_edge
  import pcint_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t sync_i,
  output pin_vec_t chg_o
);
  pin_vec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  assign chg_o = level_change(sync_i, prev_q);

  // A reported change must match the previous synchronized sample.
  AST_EDGE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg_o & ~(sync_i ^ $past(sync_i))) == '0)); // R2
endmodule

// File: rtl/pcint_regs.sv
module pcint_regs
  import pcint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  pin_vec_t          wdata_i,
  input  pin_vec_t          flags_i,
  output grp_vec_t          en_o,
  output pin_vec_t          clr_o,
  output pin_vec_t          rdata_o
);
  grp_vec_t en_q;
  logic     wr_flags;
  logic     wr_en;

  assign wr_flags = wr_i && (addr_i == ADDR_FLAGS);
  assign wr_en    = wr_i && (addr_i == ADDR_ENABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wdata_i[NGRP-1:0];
  end

  assign en_o  = en_q;
  assign clr_o = wr_flags ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      ADDR_FLAGS:  rdata_o = flags_i;
      ADDR_ENABLE: rdata_o = {{(NPINS-NGRP){1'b0}}, en_q};
      default:     rdata_o = '0;
    endcase
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_o == $past(wdata_i[NGRP-1:0]))); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_o)); // R9
endmodule

// File: rtl/pcint_flags.sv
module pcint_flags
  import pcint_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t set_i,
  input  pin_vec_t clr_i,
  output pin_vec_t flags_o,
  output logic     irq_o
);
  pin_vec_t flags_q;
  logic     irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flag_next(flags_q, set_i, clr_i);
      irq_q   <= |flags_q;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R6
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0)); // R5
  AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags_q & $past(flags_q) & ~$past(clr_i)) == '0)); // R5
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past(flags_q) != '0))); // R8
endmodule

// File: rtl/pcint_top.sv
module pcint_top
  import pcint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              irq_o
);
  pin_vec_t pin_sync;
  pin_vec_t pin_chg;
  pin_vec_t set_evt;
  pin_vec_t clr_req;
  pin_vec_t flags;
  grp_vec_t grp_en;

  pcint_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  pcint_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (pin_sync),
    .chg_o  (pin_chg)
  );

  assign set_evt = pin_chg & group_mask(grp_en);

  pcint_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .flags_i (flags),
    .en_o    (grp_en),
    .clr_o   (clr_req),
    .rdata_o (rdata_o)
  );

  pcint_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_evt),
    .clr_i   (clr_req),
    .flags_o (flags),
    .irq_o   (irq_o)
  );

  AST_GROUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en == '0) |-> (set_evt == '0)); // R3
  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i || addr_i != ADDR_FLAGS) |=> ((flags & $past(flags)) == $past(flags))); // R7
endmodule

// File: tb/tb_pcint_top.sv
module tb_pcint_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int tests = 0;
  int fails = 0;

  pcint_top dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .addr_i(addr_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {enable, new pin levels, expected flags}
  localparam logic [23:0] VEC [8] = '{
    {8'h01, 8'h0F, 8'h0F},
    {8'h02, 8'hF0, 8'hF0},
    {8'h03, 8'hA5, 8'h55},
    {8'h00, 8'h5A, 8'h00},
    {8'h03, 8'h5B, 8'h01},
    {8'h02, 8'h00, 8'h50},
    {8'h01, 8'h81, 8'h01},
    {8'h03, 8'h7E, 8'hFF}
  };

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    step();
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    @(negedge clk);
    step();
    rst_n = 1'b1;
    step();
    rd(2'd0, r); check("R1 flags after reset", r, 8'h00);
    rd(2'd1, r); check("R1 enables after reset", r, 8'h00);
    check("R1 irq after reset", {7'b0, irq_o}, 8'h00);

    // Table walk: R2 / R3 group gating of both edge directions
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, VEC[i][23:16]);
      pin_i = VEC[i][15:8];
      step(); step(); step();
      rd(2'd0, r); check($sformatf("R2 R3 vector %0d flags", i), r, VEC[i][7:0]);
      step();
      check($sformatf("R8 vector %0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][7:0] != 8'h00});
      wr(2'd0, 8'hFF);
      rd(2'd0, r); check($sformatf("R4 vector %0d clear all", i), r, 8'h00);
    end

    // Enable readback masks unused bits
    wr(2'd1, 8'hFF);
    rd(2'd1, r); check("R3 enable readback", r, 8'h03);

    // Set flag0, then collide a clear with a new event on pin 0
    pin_i = 8'h7F; step(); step(); step();
    rd(2'd0, r); check("R2 flag0 set", r, 8'h01);
    pin_i = 8'h7E; step(); step();
    wr(2'd0, 8'h01);
    rd(2'd0, r); check("R6 set wins over clear", r, 8'h01);

    wr(2'd0, 8'h00);
    rd(2'd0, r); check("R5 write zero no effect", r, 8'h01);

    pin_i = 8'h81; step(); step(); step();
    rd(2'd0, r); check("R2 all flags set", r, 8'hFF);
    wr(2'd0, 8'h04);
    rd(2'd0, r); check("R4 single bit clear", r, 8'hFB);

    wr(2'd1, 8'h00);
    rd(2'd0, r); check("R7 pending kept after disable", r, 8'hFB);
    pin_i = 8'h85; step(); step(); step(); step();
    rd(2'd0, r); check("R3 disabled group sets nothing", r, 8'hFB);

    wr(2'd0, 8'hFF);
    rd(2'd0, r); check("R4 clear remaining", r, 8'h00);
    check("R8 irq still high one cycle", {7'b0, irq_o}, 8'h01);
    step();
    check("R8 irq falls after clear", {7'b0, irq_o}, 8'h00);

    // Exact latency of flag and irq
    wr(2'd1, 8'h01);
    pin_i = 8'h87; step(); step();
    rd(2'd0, r); check("R2 flag not early", r, 8'h00);
    step();
    rd(2'd0, r); check("R2 flag on third edge", r, 8'h02);
    check("R8 irq not yet", {7'b0, irq_o}, 8'h00);
    step();
    check("R8 irq on next edge", {7'b0, irq_o}, 8'h01);

    // Unused addresses
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd0, r); check("R9 unused write keeps flags", r, 8'h02);
    rd(2'd1, r); check("R9 unused write keeps enables", r, 8'h01);
    rd(2'd2, r); check("R9 address 2 reads zero", r, 8'h00);
    rd(2'd3, r); check("R9 address 3 reads zero", r, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule